// File: doc/BRIEF.md
# Count-Register Branch Execution Unit

This unit executes one kind of control-transfer instruction: a conditional jump whose destination is held in a count register. It keeps three 32-bit architectural registers: a program counter, a link register and the count register. It accepts one instruction word per clock, qualified by a valid strobe, together with a 32-bit condition vector. When the word is recognised as the jump, the unit evaluates the condition, selects the next address, and optionally records the return address in the link register. Any other valid word simply advances the program counter by four.

The unit also reports malformed encodings. An encoding that asks for the count register to be decremented is flagged as invalid and handled as a plain fall-through. A word with a nonzero reserved field is flagged but still executed. A separate load port writes the count register. That port is the only way the count register ever changes.

Bit positions below use MSB-first numbering: instruction bit k is vector bit `31-k`. The 5-bit control field sits in instruction bits 6..10. Its element j (j = 0 is the field's most significant bit) is vector bit `25-j`.

Top module: `ctr_branch_unit`

## Requirements
- R1: A synchronous active-high reset clears pc_o, lr_o, cnt_o and all four flag outputs to zero.
- R2: A valid word that is not the jump sets pc_o to pc_o+4 and leaves lr_o alone. With instr_valid low, pc_o and lr_o hold, and the flags read zero on the next cycle.
- R3: A word is the jump only when vector bits 31:26 equal 19 and vector bits 10:1 equal 528. is_branch_o shows this one cycle after the word is accepted.
- R4: When control element 0 (vector bit 25) is 1, the condition vector is not consulted and the jump is taken. This holds for every value of the selector field (vector bits 20:16).
- R5: When control element 0 is 0, the jump is taken only if cond_reg[31-sel] equals control element 1 (vector bit 24). Here sel is vector bits 20:16.
- R6: A taken jump loads pc_o with {cnt_o[31:2], 2'b00}. A valid jump that is not taken loads pc_o+4.
- R7: When vector bit 0 (link) is 1 on a valid, non-invalid jump, lr_o receives the old pc_o+4, whether or not the jump is taken. With link at 0, lr_o is unchanged.
- R8: A jump with control element 2 (vector bit 23) at 0 raises invalid_o. It is treated as not taken (pc_o+4) and never writes lr_o.
- R9: A jump with any nonzero bit in vector bits 15:11 raises reserved_o and otherwise executes normally.
- R10: The unconditional encoding, control = 5'b10100 with sel = 0, always jumps. With link = 1 it also writes lr_o.
- R11: Control element 4 (vector bit 21) has no effect on the outcome, the pc_o value or the lr_o value.
- R12: cnt_o changes only through cnt_load, which takes cnt_load_val on the next edge. An instruction accepted in the same cycle uses the count value from before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word qualifier |
| instr | input | 32 | Instruction word |
| cond_reg | input | 32 | Condition vector tested by the jump |
| cnt_load | input | 1 | Count register write strobe |
| cnt_load_val | input | 32 | Value written to the count register |
| pc_o | output | 32 | Program counter |
| lr_o | output | 32 | Link register |
| cnt_o | output | 32 | Count register |
| is_branch_o | output | 1 | Last accepted word was the jump |
| taken_o | output | 1 | Last accepted jump was taken |
| invalid_o | output | 1 | Last accepted jump had an invalid form |
| reserved_o | output | 1 | Last accepted jump had a nonzero reserved field |

## Verification
All results arrive exactly one edge after the word or load is presented: pc_o, lr_o, cnt_o and the four flags are registered together, and nothing is combinational to the outputs. The bench applies stimulus on the falling edge and advances a behavioural model by one step per rising edge. It then compares every output with the model on the next falling edge, so each comparison lands on the cycle in which the result first becomes visible. Cycles with the valid strobe low are compared in the same way, which checks holding behaviour as well as execution.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

    localparam int          INSN_W      = 32;
    localparam logic [5:0]  OPC_PRIMARY = 6'd19;
    localparam logic [9:0]  OPC_EXT     = 10'd528;

    // decoded view of one instruction word
    typedef struct packed {
        logic       is_br;
        logic [4:0] ctl;      // ctl[4] is element 0 (MSB-first)
        logic [4:0] sel;
        logic       rsv_nz;
        logic       link;
    } dec_t;

    // registered status of the last accepted word
    typedef struct packed {
        logic is_branch;
        logic taken;
        logic invalid;
        logic reserved;
    } flags_t;

    // pick bit k of a word counted from the MSB
    function automatic logic msb_first_bit(logic [INSN_W-1:0] w, logic [4:0] k);
        return w[5'd31 - k];
    endfunction

endpackage

// File: rtl/bcu_decode.sv
module bcu_decode
    import bcu_pkg::*;
(
    input  logic [INSN_W-1:0] instr,
    output dec_t              dec
);

    always_comb begin
        dec.is_br  = (instr[31:26] == OPC_PRIMARY) && (instr[10:1] == OPC_EXT);
        dec.ctl    = instr[25:21];
        dec.sel    = instr[20:16];
        dec.rsv_nz = |instr[15:11];
        dec.link   = instr[0];
    end

endmodule

// File: rtl/bcu_resolve.sv
module bcu_resolve
    import bcu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  dec_t              dec,
    input  logic [INSN_W-1:0] cond_reg,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] cnt,
    output logic              taken,
    output logic              invalid,
    output logic              wr_link,
    output logic [ADDR_W-1:0] seq_pc,
    output logic [ADDR_W-1:0] next_pc
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    logic cond_ok;
    // hint and element 3 play no part in the outcome; low count bits are dropped
    logic unused_bits;
    assign unused_bits = ^{dec.ctl[1:0], cnt[1:0]};

    always_comb begin
        cond_ok = dec.ctl[4] | (msb_first_bit(cond_reg, dec.sel) == dec.ctl[3]);
        invalid = dec.is_br & ~dec.ctl[2];
        taken   = dec.is_br & ~invalid & cond_ok;
        wr_link = dec.is_br & ~invalid & dec.link;
        seq_pc  = pc + STEP;
        next_pc = taken ? {cnt[ADDR_W-1:2], 2'b00} : seq_pc;
    end

endmodule

// File: rtl/bcu_state.sv
module bcu_state
    import bcu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic [ADDR_W-1:0] seq_pc,
    input  logic              wr_link,
    input  flags_t            flags_in,
    input  logic              cnt_load,
    input  logic [ADDR_W-1:0] cnt_load_val,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] lr,
    output logic [ADDR_W-1:0] cnt,
    output flags_t            flags
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= '0;
            lr    <= '0;
            cnt   <= '0;
            flags <= '0;
        end else begin
            if (cnt_load)
                cnt <= cnt_load_val;
            if (step) begin
                pc <= next_pc;
                if (wr_link)
                    lr <= seq_pc;
                flags <= flags_in;
            end else begin
                flags <= '0;
            end
        end
    end

endmodule

// File: rtl/ctr_branch_unit.sv
module ctr_branch_unit
    import bcu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [INSN_W-1:0] instr,
    input  logic [INSN_W-1:0] cond_reg,
    input  logic              cnt_load,
    input  logic [ADDR_W-1:0] cnt_load_val,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] lr_o,
    output logic [ADDR_W-1:0] cnt_o,
    output logic              is_branch_o,
    output logic              taken_o,
    output logic              invalid_o,
    output logic              reserved_o
);

    dec_t              dec;
    flags_t            nxt_flags;
    flags_t            cur_flags;
    logic              taken;
    logic              invalid;
    logic              wr_link;
    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] next_pc;

    bcu_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    bcu_resolve #(.ADDR_W(ADDR_W)) u_res (
        .dec      (dec),
        .cond_reg (cond_reg),
        .pc       (pc_o),
        .cnt      (cnt_o),
        .taken    (taken),
        .invalid  (invalid),
        .wr_link  (wr_link),
        .seq_pc   (seq_pc),
        .next_pc  (next_pc)
    );

    always_comb begin
        nxt_flags.is_branch = dec.is_br;
        nxt_flags.taken     = taken;
        nxt_flags.invalid   = invalid;
        nxt_flags.reserved  = dec.is_br & dec.rsv_nz;
    end

    bcu_state #(.ADDR_W(ADDR_W)) u_st (
        .clk          (clk),
        .rst          (rst),
        .step         (instr_valid),
        .next_pc      (next_pc),
        .seq_pc       (seq_pc),
        .wr_link      (wr_link),
        .flags_in     (nxt_flags),
        .cnt_load     (cnt_load),
        .cnt_load_val (cnt_load_val),
        .pc           (pc_o),
        .lr           (lr_o),
        .cnt          (cnt_o),
        .flags        (cur_flags)
    );

    assign is_branch_o = cur_flags.is_branch;
    assign taken_o     = cur_flags.taken;
    assign invalid_o   = cur_flags.invalid;
    assign reserved_o  = cur_flags.reserved;

endmodule

// File: rtl/ctr_branch_unit_chk.sv
module ctr_branch_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              instr_valid,
    input logic [31:0]       instr,
    input logic [31:0]       cond_reg,
    input logic              cnt_load,
    input logic [ADDR_W-1:0] cnt_load_val,
    input logic [ADDR_W-1:0] pc_o,
    input logic [ADDR_W-1:0] lr_o,
    input logic [ADDR_W-1:0] cnt_o,
    input logic              is_branch_o,
    input logic              taken_o,
    input logic              invalid_o,
    input logic              reserved_o
);

    // R2: idle cycles hold pc and lr
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> ($stable(pc_o) && $stable(lr_o)));

    // R2: a non-jump word never touches lr
    p_other_no_link_r2: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr[31:26] != 6'd19) |=> $stable(lr_o));

    // R12: count register moves only on a load
    p_cnt_only_load_r12: assert property (@(posedge clk) disable iff (rst)
        !cnt_load |=> $stable(cnt_o));

    // R12: a load lands on the next edge
    p_cnt_load_r12: assert property (@(posedge clk) disable iff (rst)
        cnt_load |=> (cnt_o == $past(cnt_load_val)));

    // R8: invalid form is never taken
    p_invalid_not_taken_r8: assert property (@(posedge clk) disable iff (rst)
        invalid_o |-> !taken_o);

    // R3: every jump flag implies recognition
    p_flags_need_branch_r3: assert property (@(posedge clk) disable iff (rst)
        (taken_o || invalid_o || reserved_o) |-> is_branch_o);

    // R6: pc stays word aligned
    p_pc_aligned_r6: assert property (@(posedge clk) disable iff (rst)
        pc_o[1:0] == 2'b00);

endmodule

bind ctr_branch_unit ctr_branch_unit_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/ctr_branch_unit_test.sv
module ctr_branch_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [31:0] instr;
    logic [31:0] cond_reg;
    logic        cnt_load;
    logic [31:0] cnt_load_val;
    logic [31:0] pc_o, lr_o, cnt_o;
    logic        is_branch_o, taken_o, invalid_o, reserved_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference state
    logic [31:0] m_pc, m_lr, m_cnt;
    logic        m_br, m_tk, m_inv, m_rsv;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctr_branch_unit uut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .cond_reg(cond_reg), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
        .pc_o(pc_o), .lr_o(lr_o), .cnt_o(cnt_o), .is_branch_o(is_branch_o),
        .taken_o(taken_o), .invalid_o(invalid_o), .reserved_o(reserved_o)
    );

    function automatic logic bbit(logic [31:0] w, int k);
        return w[31-k];
    endfunction

    function automatic logic [31:0] enc(logic [4:0] ctl, logic [4:0] sel,
                                        logic [4:0] rsv, logic lnk);
        return {6'd19, ctl, sel, rsv, 10'd528, lnk};
    endfunction

    task automatic compare(string req);
        checks++;
        if (pc_o !== m_pc || lr_o !== m_lr || cnt_o !== m_cnt ||
            is_branch_o !== m_br || taken_o !== m_tk ||
            invalid_o !== m_inv || reserved_o !== m_rsv) begin
            errors++;
            $display("FAIL %s: actual pc=%h lr=%h cnt=%h flags=%b%b%b%b expected pc=%h lr=%h cnt=%h flags=%b%b%b%b",
                     req, pc_o, lr_o, cnt_o, is_branch_o, taken_o, invalid_o, reserved_o,
                     m_pc, m_lr, m_cnt, m_br, m_tk, m_inv, m_rsv);
        end
    endtask

    // advance the model by one edge from current model state
    task automatic model_step(logic v, logic [31:0] w, logic [31:0] c,
                              logic ld, logic [31:0] ldv);
        int opc, xop, sel;
        logic jump, bad, go;
        logic [31:0] seq;
        opc  = int'(w[31:26]);
        xop  = int'(w[10:1]);
        sel  = int'(w[20:16]);
        jump = (opc == 19) && (xop == 528);
        bad  = jump && !bbit(w, 8);
        go   = jump && !bad && (bbit(w, 6) || (bbit(c, sel) == bbit(w, 7)));
        seq  = m_pc + 32'd4;
        if (v) begin
            if (jump && !bad && bbit(w, 31)) m_lr = seq;
            m_pc  = go ? {m_cnt[31:2], 2'b00} : seq;
            m_br  = jump;
            m_tk  = go;
            m_inv = bad;
            m_rsv = jump && (w[15:11] != 5'd0);
        end else begin
            {m_br, m_tk, m_inv, m_rsv} = 4'b0;
        end
        if (ld) m_cnt = ldv;
    endtask

    task automatic cyc(string req, logic v, logic [31:0] w, logic [31:0] c,
                       logic ld = 1'b0, logic [31:0] ldv = 32'h0);
        instr_valid  = v;
        instr        = w;
        cond_reg     = c;
        cnt_load     = ld;
        cnt_load_val = ldv;
        model_step(v, w, c, ld, ldv);
        @(posedge clk);
        @(negedge clk);
        compare(req);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        instr_valid = 0; instr = 0; cond_reg = 0; cnt_load = 0; cnt_load_val = 0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_pc = 0; m_lr = 0; m_cnt = 0;
        {m_br, m_tk, m_inv, m_rsv} = 4'b0;
    endtask

    localparam logic [31:0] ADD_LIKE = 32'h7C00_0214;

    initial begin
        @(negedge clk);
        // R1: state after reset
        do_reset();
        compare("R1 reset");

        // R2: sequential advance and idle hold
        cyc("R2 other word", 1, ADD_LIKE, 32'h0);
        cyc("R2 other word", 1, ADD_LIKE, 32'hFFFF_FFFF);
        cyc("R2 idle", 0, enc(5'b10100, 0, 0, 1), 32'h0);

        // R12: load count register
        cyc("R12 load", 0, 32'h0, 32'h0, 1, 32'h1234_5677);
        cyc("R12 hold", 1, ADD_LIKE, 32'h0);

        // R3: near-miss encodings are not jumps
        cyc("R3 wrong ext", 1, enc(5'b10100, 0, 0, 1) ^ 32'h0000_0002, 32'h0);
        cyc("R3 wrong primary", 1, enc(5'b10100, 0, 0, 1) ^ 32'h0400_0000, 32'h0);

        // R10: unconditional, then with link
        cyc("R10 uncond", 1, enc(5'b10100, 0, 0, 0), 32'h0);
        cyc("R10 uncond link", 1, enc(5'b10100, 0, 0, 1), 32'h0);

        // R11: hint bit has no effect
        cyc("R11 hint", 1, enc(5'b10101, 0, 0, 1), 32'h0);

        // R4: bypass with arbitrary selector and condition
        cyc("R4 bypass", 1, enc(5'b10100, 5'd17, 0, 0), 32'h0000_0000);
        cyc("R4 bypass", 1, enc(5'b11100, 5'd3, 0, 1), 32'hFFFF_FFFF);

        // R5/R6/R7: conditional, taken and not-taken, with link
        cyc("R5 sel0 set want1", 1, enc(5'b01100, 5'd0, 0, 0), 32'h8000_0000);
        cyc("R5 sel0 clr want1", 1, enc(5'b01100, 5'd0, 0, 1), 32'h7FFF_FFFF);
        cyc("R5 sel31 clr want0", 1, enc(5'b00100, 5'd31, 0, 1), 32'hFFFF_FFFE);
        cyc("R6 not taken", 1, enc(5'b00100, 5'd5, 0, 0), 32'h0400_0000);
        cyc("R7 no link", 1, enc(5'b00100, 5'd5, 0, 0), 32'h0000_0000);

        // R8: invalid form with link and true condition
        cyc("R8 invalid", 1, enc(5'b10000, 0, 0, 1), 32'h0);
        cyc("R8 invalid", 1, enc(5'b01000, 5'd2, 0, 1), 32'h2000_0000);

        // R9: reserved field set, still executes
        cyc("R9 reserved", 1, enc(5'b10100, 0, 5'b00011, 1), 32'h0);
        cyc("R9 reserved nt", 1, enc(5'b01100, 5'd9, 5'b10000, 0), 32'h0);

        // R12: load and jump together use the old count
        cyc("R12 load+jump", 1, enc(5'b10100, 0, 0, 0), 32'h0, 1, 32'hCAFE_F00D);
        cyc("R12 new count", 1, enc(5'b10100, 0, 0, 1), 32'h0);

        // R1: reset in the middle of activity
        do_reset();
        compare("R1 re-reset");
        cyc("R2 after reset", 1, ADD_LIKE, 32'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule